// File: doc/BRIEF.md
# Indirect Command Register Bridge

This block gives a host a narrow window onto an internal 32-bit peripheral bus. The host sees four 64-bit registers selected by two address bits: a command register, an inert reset slot, a status register and a data register. The host places a 32-bit write word in the data register, then writes a command word that carries a direction flag, a byte count and a 32-bit bus address. The command write starts exactly one transaction on the peripheral bus.

The bridge drives a request/grant master port and then waits for a response pulse that carries an error flag and returned data. Bytes go onto the bus lanes most significant byte first. Returned lanes are packed into a 32-bit field in the middle of the status word. The status register records the result and clears when the host reads it. While a transaction is in flight the bridge reports busy, and it drops any further command writes.

Top module: `icb_bridge`

## Requirements
- R1: The register is chosen by host_addr[4:3]: 0 is command, 1 is reset, 2 is status, 3 is data. All other address bits are ignored.
- R2: An access whose host_bytes is not 8 has no effect on any register and reads back zero.
- R3: A data register write keeps host_wdata[63:32] as the data word. A data register read returns that word in bits 63:32, with zeros below. Reset clears the word to zero.
- R4: Reads of the command and reset slots return zero. Writes to the status register and to the reset slot change nothing.
- R5: A command write while idle starts a transaction. bus_we is the inverse of bit 48, bus_size is bits 59:56 and bus_addr is bits 31:0. bus_req stays high with stable fields until a cycle with bus_gnt high.
- R6: busy is high from the command write until the cycle after the response pulse. A command write while busy is ignored.
- R7: Let n be the smaller of bus_size and 4. bus_be enables lanes 0..n-1, where lane k is bits 8k+7:8k. Lane k of bus_wdata carries byte k of the data word counted from its most significant byte. Lanes that are not enabled carry zero.
- R8: A read without error sets status to bit 11 plus the returned lanes in bits 57:26. Lane 0 is the most significant byte of that field. Lanes that are not enabled read as zero.
- R9: A read with error sets status to bit 11 plus all ones in bits 57:26.
- R10: A completed write sets status to bit 11 alone, with or without error.
- R11: A status read returns the current value, and the register is zero from the next cycle. If a response completes in the same cycle as the read, the new result is kept.
- R12: After reset: status zero, busy low, bus_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host access strobe |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HOST_AW | Host byte address; bits 4:3 select the register |
| host_bytes | input | 4 | Access size in bytes; only 8 is accepted |
| host_wdata | input | 64 | Host write value |
| host_rdata | output | 64 | Read value, valid in the access cycle |
| busy | output | 1 | Transaction in flight |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_we | output | 1 | Bus transfer is a write |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 4 | Requested byte count |
| bus_be | output | 4 | Lane enables |
| bus_wdata | output | 32 | Write lanes |
| bus_rsp_valid | input | 1 | Response pulse |
| bus_rsp_err | input | 1 | Response error flag |
| bus_rdata | input | 32 | Returned lanes |

## Verification
The assertions check on every cycle that a request holds with stable fields until granted, that command writes made while busy leave the bus fields unchanged, that lane enables are always a contiguous low group, and that a status read with no coinciding response clears the register. They also check the status values after failed reads and after writes, and that rejected access sizes read zero. The bench scenarios are needed to show the byte order of the lanes, the exact packing of returned bytes into the status field for each size, the same-cycle collision of a status read with a response, and the address aliasing through the upper address bits.

// File: rtl/icb_pkg.sv
package icb_pkg;
  localparam int BUS_DW     = 32;
  localparam int LANES      = BUS_DW / 8;
  localparam int REG_DW     = 64;
  localparam int CMD_RD_BIT = 48;
  localparam int CMD_SZ_LO  = 56;
  localparam int STAT_DONE  = 11;
  localparam int STAT_FLD   = 26;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_RST  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  typedef enum logic [1:0] {M_IDLE, M_REQ, M_WAIT} mst_state_e;

  // enables for the lowest min(size, LANES) lanes
  function automatic logic [LANES-1:0] lane_mask(input logic [3:0] size);
    logic [LANES-1:0] m;
    for (int k = 0; k < LANES; k++) m[k] = (32'(size) > k);
    return m;
  endfunction

  // data word -> lanes, most significant byte on lane 0
  function automatic logic [BUS_DW-1:0] pack_lanes(input logic [BUS_DW-1:0] w,
                                                   input logic [LANES-1:0] m);
    logic [BUS_DW-1:0] r;
    r = '0;
    for (int k = 0; k < LANES; k++)
      if (m[k]) r[8*k +: 8] = w[BUS_DW-8-8*k +: 8];
    return r;
  endfunction

  // lanes -> data word, lane 0 becomes the most significant byte
  function automatic logic [BUS_DW-1:0] unpack_lanes(input logic [BUS_DW-1:0] l,
                                                     input logic [LANES-1:0] m);
    logic [BUS_DW-1:0] r;
    r = '0;
    for (int k = 0; k < LANES; k++)
      if (m[k]) r[BUS_DW-8-8*k +: 8] = l[8*k +: 8];
    return r;
  endfunction

  function automatic logic [REG_DW-1:0] status_word(input logic is_rd, input logic err,
                                                    input logic [BUS_DW-1:0] w);
    logic [REG_DW-1:0] s;
    s = '0;
    s[STAT_DONE] = 1'b1;
    if (is_rd) s[STAT_FLD +: BUS_DW] = err ? '1 : w;
    return s;
  endfunction
endpackage

// File: rtl/icb_decode.sv
module icb_decode
  import icb_pkg::*;
(
  input  logic       host_valid,
  input  logic       host_we,
  input  logic [1:0] sel_bits,
  input  logic [3:0] host_bytes,
  output logic       acc_ok,
  output logic       cmd_wr,
  output logic       data_wr,
  output logic       stat_rd
);
  assign acc_ok  = host_valid && (host_bytes == 4'd8);
  assign cmd_wr  = acc_ok &&  host_we && (sel_bits == SEL_CMD);
  assign data_wr = acc_ok &&  host_we && (sel_bits == SEL_DATA);
  assign stat_rd = acc_ok && !host_we && (sel_bits == SEL_STAT);
endmodule

// File: rtl/icb_master.sv
module icb_master
  import icb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [REG_DW-1:0] cmd_word,
  input  logic [BUS_DW-1:0] data_word,
  output logic              busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [31:0]       bus_addr,
  output logic [3:0]        bus_size,
  output logic [LANES-1:0]  bus_be,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [BUS_DW-1:0] bus_rdata,
  output logic              rsp_done,
  output logic              rsp_is_rd,
  output logic              rsp_err,
  output logic [BUS_DW-1:0] rsp_word
);
  mst_state_e        st_q;
  logic              we_q;
  logic [31:0]       addr_q;
  logic [3:0]        size_q;
  logic [BUS_DW-1:0] word_q;
  logic              launch;

  logic unused_cmd;
  assign unused_cmd = ^{cmd_word[63:60], cmd_word[55:49], cmd_word[47:32]};

  assign launch = cmd_wr && (st_q == M_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_IDLE;
      we_q   <= 1'b0;
      addr_q <= '0;
      size_q <= '0;
      word_q <= '0;
    end else begin
      unique case (st_q)
        M_IDLE: if (launch) begin
          we_q   <= !cmd_word[CMD_RD_BIT];
          size_q <= cmd_word[CMD_SZ_LO +: 4];
          addr_q <= cmd_word[31:0];
          word_q <= data_word;
          st_q   <= M_REQ;
        end
        M_REQ:  if (bus_gnt) st_q <= M_WAIT;
        M_WAIT: if (bus_rsp_valid) st_q <= M_IDLE;
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != M_IDLE);
  assign bus_req   = (st_q == M_REQ);
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_size  = size_q;
  assign bus_be    = lane_mask(size_q);
  assign bus_wdata = we_q ? pack_lanes(word_q, bus_be) : '0;

  assign rsp_done  = (st_q == M_WAIT) && bus_rsp_valid;
  assign rsp_is_rd = !we_q;
  assign rsp_err   = bus_rsp_err;
  assign rsp_word  = unpack_lanes(bus_rdata, bus_be);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));
  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));
  // R7
  be_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ((4'(bus_be + 4'd1) & bus_be) == 4'd0));
endmodule

// File: rtl/icb_status.sv
module icb_status
  import icb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              rsp_done,
  input  logic              rsp_is_rd,
  input  logic              rsp_err,
  input  logic [BUS_DW-1:0] rsp_word,
  output logic [REG_DW-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= '0;
    else if (rsp_done) status <= status_word(rsp_is_rd, rsp_err, rsp_word);
    else if (stat_rd)  status <= '0;
  end

  // R11
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !rsp_done |=> status == '0);
  // R9
  rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_is_rd && rsp_err |=> status[STAT_DONE] && (status[STAT_FLD +: BUS_DW] == '1));
  // R10
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !rsp_is_rd |=> status == (64'd1 << STAT_DONE));
endmodule

// File: rtl/icb_bridge.sv
module icb_bridge
  import icb_pkg::*;
#(
  parameter int HOST_AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [3:0]         host_bytes,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               busy,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               bus_we,
  output logic [31:0]        bus_addr,
  output logic [3:0]         bus_size,
  output logic [3:0]         bus_be,
  output logic [31:0]        bus_wdata,
  input  logic               bus_rsp_valid,
  input  logic               bus_rsp_err,
  input  logic [31:0]        bus_rdata
);
  logic              acc_ok, cmd_wr, data_wr, stat_rd;
  logic [1:0]        sel;
  logic [BUS_DW-1:0] data_q;
  logic [REG_DW-1:0] status;
  logic              rsp_done, rsp_is_rd, rsp_err;
  logic [BUS_DW-1:0] rsp_word;

  logic unused_host;
  assign unused_host = ^{host_addr, host_wdata[31:0]};

  assign sel = host_addr[4:3];

  icb_decode u_dec (
    .host_valid(host_valid), .host_we(host_we), .sel_bits(sel),
    .host_bytes(host_bytes), .acc_ok(acc_ok), .cmd_wr(cmd_wr),
    .data_wr(data_wr), .stat_rd(stat_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= host_wdata[63:32];
  end

  icb_master u_mst (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(host_wdata),
    .data_word(data_q), .busy(busy), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .bus_rdata(bus_rdata), .rsp_done(rsp_done), .rsp_is_rd(rsp_is_rd),
    .rsp_err(rsp_err), .rsp_word(rsp_word)
  );

  icb_status u_st (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .rsp_done(rsp_done),
    .rsp_is_rd(rsp_is_rd), .rsp_err(rsp_err), .rsp_word(rsp_word), .status(status)
  );

  always_comb begin
    host_rdata = '0;
    if (acc_ok && !host_we) begin
      unique case (sel)
        SEL_STAT: host_rdata = status;
        SEL_DATA: host_rdata = {data_q, 32'd0};
        default:  host_rdata = '0;
      endcase
    end
  end

  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && (host_bytes != 4'd8) |-> host_rdata == '0);
  // R6
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);
endmodule

// File: tb/tb_icb_bridge.sv
module tb_icb_bridge;
  logic        clk = 0, rst_n = 0;
  logic        host_valid = 0, host_we = 0;
  logic [15:0] host_addr = 0;
  logic [3:0]  host_bytes = 4'd8;
  logic [63:0] host_wdata = 0, host_rdata;
  logic        busy, bus_req, bus_we, bus_gnt = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic [3:0]  bus_size, bus_be;
  logic        bus_rsp_valid = 0, bus_rsp_err = 0;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  icb_bridge dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nlanes(input logic [3:0] s);
    return (s > 4) ? 4 : int'(s);
  endfunction
  function automatic logic [3:0] exp_be(input logic [3:0] s);
    return 4'((5'd1 << nlanes(s)) - 5'd1);
  endfunction
  function automatic logic [31:0] exp_wlanes(input logic [31:0] w, input logic [3:0] s);
    logic [31:0] r = 0;
    for (int k = 0; k < nlanes(s); k++) r |= ((w >> (24 - 8*k)) & 32'hff) << (8*k);
    return r;
  endfunction
  function automatic logic [63:0] exp_stat(input bit rd, input bit err,
                                           input logic [31:0] l, input logic [3:0] s);
    logic [31:0] f = 0;
    if (!rd) return 64'h800;
    if (err) f = 32'hffff_ffff;
    else for (int k = 0; k < nlanes(s); k++) f |= ((l >> (8*k)) & 32'hff) << (24 - 8*k);
    return 64'h800 | (64'(f) << 26);
  endfunction

  task automatic acc(input bit we, input logic [15:0] a, input logic [3:0] b,
                     input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    host_valid = 1; host_we = we; host_addr = a; host_bytes = b; host_wdata = wd;
    #1 rd = host_rdata;
    @(posedge clk); #1;
    host_valid = 0; host_we = 0; host_bytes = 4'd8;
  endtask

  function automatic logic [15:0] ra(input logic [1:0] idx, input logic [10:0] hi);
    return {hi, idx, 3'b000};
  endfunction

  function automatic logic [63:0] cmdw(input bit rd, input logic [3:0] s, input logic [31:0] a);
    return (64'(s) << 56) | (64'(rd) << 48) | 64'(a);
  endfunction

  task automatic grant_and_respond(input int gd, input int rd_dly, input bit err,
                                   input logic [31:0] lanes);
    repeat (gd) @(posedge clk);
    @(negedge clk); bus_gnt = 1;
    @(posedge clk); #1 bus_gnt = 0;
    repeat (rd_dly) @(posedge clk);
    @(negedge clk); bus_rsp_valid = 1; bus_rsp_err = err; bus_rdata = lanes;
    @(posedge clk); #1 bus_rsp_valid = 0; bus_rsp_err = 0;
  endtask

  task automatic txn(input bit rd, input logic [3:0] s, input logic [31:0] a,
                     input logic [31:0] w, input bit err, input logic [31:0] lanes,
                     input int gd, input int rdl, input logic [10:0] hi);
    logic [63:0] r;
    acc(1, ra(2'd3, hi), 8, {w, 32'h5a5a_a5a5}, r);
    acc(1, ra(2'd0, hi), 8, cmdw(rd, s, a), r);
    check("R5 req", bus_req, 1);
    check("R6 busy", busy, 1);
    check("R5 we", bus_we, !rd);
    check("R5 addr", bus_addr, a);
    check("R5 size", bus_size, s);
    check("R7 be", bus_be, exp_be(s));
    if (!rd) check("R7 lanes", bus_wdata, exp_wlanes(w, s));
    grant_and_respond(gd, rdl, err, lanes);
    check("R6 idle after rsp", busy, 0);
    acc(0, ra(2'd2, hi), 8, 0, r);
    check(rd ? (err ? "R9 status" : "R8 status") : "R10 status", r, exp_stat(rd, err, lanes, s));
    acc(0, ra(2'd2, hi), 8, 0, r);
    check("R11 cleared", r, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R12 reset state
    check("R12 busy", busy, 0);
    check("R12 req", bus_req, 0);
    acc(0, ra(2'd2, 0), 8, 0, r); check("R12 status", r, 0);
    acc(0, ra(2'd3, 0), 8, 0, r); check("R3 reset data", r, 0);
    // R3 data register, R1 aliasing through upper bits
    acc(1, ra(2'd3, 11'h5f3), 8, 64'hdead_beef_1234_5678, r);
    acc(0, ra(2'd3, 11'h001), 8, 0, r); check("R3 R1 data", r, 64'hdead_beef_0000_0000);
    // R2 wrong size: ignored, reads zero
    acc(1, ra(2'd3, 0), 4, 64'h1111_2222_0000_0000, r);
    acc(0, ra(2'd3, 0), 4, 0, r); check("R2 read zero", r, 0);
    acc(0, ra(2'd3, 0), 8, 0, r); check("R2 no write", r, 64'hdead_beef_0000_0000);
    acc(1, ra(2'd0, 0), 2, cmdw(1, 4, 32'h10), r);
    check("R2 no launch", busy, 0);
    // R4 cmd/reset read zero, reset write inert
    acc(0, ra(2'd0, 0), 8, 0, r); check("R4 cmd read", r, 0);
    acc(1, ra(2'd1, 0), 8, 64'hffff_ffff_ffff_ffff, r);
    check("R4 reset write", busy, 0);
    acc(0, ra(2'd1, 0), 8, 0, r); check("R4 reset read", r, 0);
    acc(0, ra(2'd3, 0), 8, 0, r); check("R4 data kept", r, 64'hdead_beef_0000_0000);
    // R4 status write ignored: complete a write, write status, read it
    acc(1, ra(2'd0, 0), 8, cmdw(0, 4, 32'h40), r);
    grant_and_respond(0, 0, 0, 0);
    acc(1, ra(2'd2, 0), 8, 64'hffff_ffff_ffff_ffff, r);
    acc(0, ra(2'd2, 0), 8, 0, r); check("R4 status write ignored", r, 64'h800);
    // R6 command while busy ignored
    acc(1, ra(2'd0, 0), 8, cmdw(1, 4, 32'hc001_2000), r);
    acc(1, ra(2'd0, 0), 8, cmdw(0, 1, 32'h0000_0077), r);
    check("R6 addr kept", bus_addr, 32'hc001_2000);
    check("R6 dir kept", bus_we, 0);
    grant_and_respond(1, 1, 0, 32'h4433_2211);
    check("R6 no second txn", busy, 0);
    acc(0, ra(2'd2, 0), 8, 0, r);
    check("R8 ordered", r, 64'h800 | (64'h1122_3344 << 26));
    // R11 read colliding with response keeps the new value
    acc(1, ra(2'd0, 0), 8, cmdw(1, 2, 32'h8), r);
    @(negedge clk); bus_gnt = 1; @(posedge clk); #1 bus_gnt = 0;
    @(negedge clk);
    bus_rsp_valid = 1; bus_rdata = 32'h0000_bbaa;
    host_valid = 1; host_we = 0; host_addr = ra(2'd2, 0); host_bytes = 8;
    #1 check("R11 old value", host_rdata, 0);
    @(posedge clk); #1 bus_rsp_valid = 0; host_valid = 0;
    acc(0, ra(2'd2, 0), 8, 0, r);
    check("R11 collision keeps", r, 64'h800 | (64'haabb_0000 << 26));
    // directed sizes 0 and 8, failed read, write with error
    txn(1, 0, 32'h1, 32'h0, 0, 32'hffff_ffff, 0, 0, 0);
    txn(1, 8, 32'h2, 32'h0, 0, 32'h0102_0304, 2, 3, 11'h7ff);
    txn(1, 4, 32'h3, 32'h0, 1, 32'h0, 0, 1, 0);
    txn(0, 3, 32'h4, 32'h8899_aabb, 1, 0, 1, 0, 0);
    // constrained random
    for (int i = 0; i < 150; i++) begin
      txn($urandom % 2, 4'($urandom % 9), $urandom, $urandom, ($urandom % 4) == 0,
          $urandom, $urandom % 4, $urandom % 4, 11'($urandom));
    end
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule